// File: doc/BRIEF.md
# Two-Entry Receive Buffer with Oldest-Byte Overwrite

This block sits between a serial shift engine and a host. Each completed byte from the engine is offered on a valid-only input stream. It is stored in one of two registers: a front register that the host sees, and a back register queued behind it. A single slot pointer decides which register takes the next byte. The pointer points at the front register while nothing is held. It points at the back register while the front register holds an unread byte.

The host side is a valid/ready stream. `out_valid` is high while the front register holds an unread byte, and `out_data` shows that byte. A cycle with both `out_valid` and `out_ready` high is a read. On a read, the front register drains and any queued back byte moves forward. The input has no ready signal and is never stalled. When a byte arrives while both registers are full and no read takes place, the oldest byte is discarded, so the two newest bytes are kept. A sticky overflow flag records each loss until the host pulses `ovf_clr`. Driving `enable` low empties the buffer and clears the flag.

Top module: `rx_pair_buffer`

## Requirements
- R1: After reset, `out_valid` and `ovf` are both 0.
- R2: A byte received while the buffer is empty appears on `out_data` with `out_valid` high in the next cycle.
- R3: A read while only the front register is full drops `out_valid` in the next cycle, unless a byte arrives in the same cycle.
- R4: With two bytes held and no read, `out_data` keeps showing the older byte. Each read then presents the next byte in arrival order, and `out_valid` falls only after the last byte is read.
- R5: A byte arriving with both registers full and no read in that cycle discards the oldest byte. The two bytes read afterwards are the second and the third, in that order.
- R6: `ovf` rises in the cycle after a byte is discarded. It stays high until a cycle with `ovf_clr` high and no discard. A discard in the same cycle as `ovf_clr` leaves `ovf` high.
- R7: A read and a receive in the same cycle with one byte held are handled read first. The new byte is shown next cycle and `out_valid` stays high.
- R8: A read and a receive in the same cycle with two bytes held lose nothing. `ovf` stays 0, and the remaining two bytes come out in arrival order.
- R9: While `enable` is low, the buffer empties, `ovf` clears and `in_valid` is ignored. The next byte after re-enabling lands in the front register.
- R10: `out_ready` while `out_valid` is low has no effect on the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Buffer enable; low empties the buffer and clears the flag |
| in_valid | input | 1 | Receive-complete strobe from the shift engine |
| in_data | input | DATA_W | Received byte |
| out_valid | output | 1 | Front register holds an unread byte |
| out_data | output | DATA_W | Front register contents |
| out_ready | input | 1 | Host read strobe; a read occurs when it is high with out_valid |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Overflow clear strobe |

## Verification
The checker watches several rules on every cycle:
- the emptying effect of `enable` and the reset state;
- an empty buffer capturing the next byte;
- the front byte holding steady while nobody reads;
- a drain to empty;
- the overflow flag rising and staying set;
- the back register never being occupied while the front register is empty.

Only the bench scenarios can show the arrival-order sequences across several reads: which byte is lost on overrun, the read-before-store ordering of a simultaneous read and receive, and the value that lands in the front register after re-enabling.

// File: rtl/rx_pair_buffer_pkg.sv
package rx_pair_buffer_pkg;
  typedef enum logic { SLOT_FRONT = 1'b0, SLOT_BACK = 1'b1 } slot_e;
  typedef enum logic [1:0] { SRC_HOLD = 2'd0, SRC_INPUT = 2'd1, SRC_BACK = 2'd2 } front_src_e;
endpackage

// File: rtl/rxb_slot_ctrl.sv
module rxb_slot_ctrl
  import rx_pair_buffer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       store,
  input  logic       take_req,
  output logic       front_full,
  output logic       back_full,
  output front_src_e front_src,
  output logic       back_load,
  output logic       drop
);
  slot_e ptr_q, ptr_d;
  logic  back_q, back_d;
  logic  take;
  logic  front_after_read, back_after_read;

  assign front_full = (ptr_q == SLOT_BACK);
  assign back_full  = back_q;
  assign take       = enable && take_req && front_full;

  always_comb begin
    front_after_read = front_full;
    back_after_read  = back_q;
    front_src        = SRC_HOLD;
    back_load        = 1'b0;
    drop             = 1'b0;
    if (take) begin
      front_after_read = back_q;
      back_after_read  = 1'b0;
      if (back_q) front_src = SRC_BACK;
    end
    ptr_d  = front_after_read ? SLOT_BACK : SLOT_FRONT;
    back_d = back_after_read;
    if (enable && store) begin
      if (!front_after_read) begin
        front_src = SRC_INPUT;
        ptr_d     = SLOT_BACK;
      end else if (!back_after_read) begin
        back_load = 1'b1;
        back_d    = 1'b1;
      end else begin
        front_src = SRC_BACK;
        back_load = 1'b1;
        drop      = 1'b1;
      end
    end
    if (!enable) begin
      ptr_d     = SLOT_FRONT;
      back_d    = 1'b0;
      front_src = SRC_HOLD;
      back_load = 1'b0;
      drop      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= SLOT_FRONT;
      back_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      back_q <= back_d;
    end
  end
endmodule

// File: rtl/rxb_byte_reg.sv
module rxb_byte_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/rxb_ovf_flag.sv
module rxb_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic drop,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (!enable) flag <= 1'b0;
    else if (drop)    flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/rx_pair_buffer.sv
module rx_pair_buffer
  import rx_pair_buffer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              ovf,
  input  logic              ovf_clr
);
  localparam int NSLOT = 2;

  logic              front_full, buf_full, back_load, drop;
  front_src_e        front_src;
  logic [DATA_W-1:0] slot_q   [NSLOT];
  logic [DATA_W-1:0] slot_d   [NSLOT];
  logic              slot_ld  [NSLOT];

  rxb_slot_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .store      (in_valid),
    .take_req   (out_ready),
    .front_full (front_full),
    .back_full  (buf_full),
    .front_src  (front_src),
    .back_load  (back_load),
    .drop       (drop)
  );

  always_comb begin
    slot_d[0]  = (front_src == SRC_BACK) ? slot_q[1] : in_data;
    slot_ld[0] = (front_src != SRC_HOLD);
    slot_d[1]  = in_data;
    slot_ld[1] = back_load;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    rxb_byte_reg #(.DATA_W(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (slot_ld[i]),
      .d     (slot_d[i]),
      .q     (slot_q[i])
    );
  end

  rxb_ovf_flag u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .drop   (drop),
    .clr    (ovf_clr),
    .flag   (ovf)
  );

  assign out_valid = front_full;
  assign out_data  = slot_q[0];
endmodule

// File: rtl/rx_pair_buffer_checker.sv
module rx_pair_buffer_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              ovf,
  input logic              ovf_clr,
  input logic              buf_full
);
  // R9
  disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && !ovf));

  // R2
  empty_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !out_valid && in_valid) |=> (out_valid && out_data == $past(in_data)));

  // R4
  hold_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_data)));

  // R3
  drain_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_valid && !buf_full && out_ready && !in_valid) |=> !out_valid);

  // R5
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && buf_full && in_valid && !out_ready) |=> ovf);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ovf && !ovf_clr) |=> ovf);

  // R4
  back_needs_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> out_valid);
endmodule

bind rx_pair_buffer rx_pair_buffer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .ovf       (ovf),
  .ovf_clr   (ovf_clr),
  .buf_full  (buf_full)
);

// File: tb/rx_pair_buffer_test.sv
module rx_pair_buffer_test;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic ovf_clr = 1'b0;
  logic out_valid, ovf;
  logic [W-1:0] out_data;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_pair_buffer #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .ovf(ovf), .ovf_clr(ovf_clr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs are settled when it returns (at a negedge)
  task automatic cyc(input logic iv, input logic [W-1:0] d, input logic rd, input logic clr);
    in_valid = iv; in_data = d; out_ready = rd; ovf_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] d); cyc(1'b1, d, 1'b0, 1'b0); endtask
  task automatic pop(); cyc(1'b0, '0, 1'b1, 1'b0); endtask

  task automatic t_reset();
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "ovf after reset", int'(ovf), 0);
  endtask

  task automatic t_single();
    push(8'hA5);
    chk("R2", "valid", int'(out_valid), 1);
    chk("R2", "data", int'(out_data), 'hA5);
    pop();
    chk("R3", "valid after read", int'(out_valid), 0);
  endtask

  task automatic t_pair();
    push(8'h11); push(8'h22);
    cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R4", "older byte shown", int'(out_data), 'h11);
    pop();
    chk("R4", "second byte shown", int'(out_data), 'h22);
    chk("R4", "still valid", int'(out_valid), 1);
    pop();
    chk("R4", "empty after two reads", int'(out_valid), 0);
    chk("R4", "no overflow", int'(ovf), 0);
  endtask

  task automatic t_overrun();
    push(8'h31); push(8'h32); push(8'h33);
    chk("R6", "ovf set on loss", int'(ovf), 1);
    chk("R5", "oldest dropped", int'(out_data), 'h32);
    pop();
    chk("R5", "newest next", int'(out_data), 'h33);
    pop();
    chk("R5", "empty", int'(out_valid), 0);
    chk("R6", "ovf sticky", int'(ovf), 1);
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk("R6", "ovf cleared", int'(ovf), 0);
  endtask

  task automatic t_clr_collision();
    push(8'h01); push(8'h02);
    cyc(1'b1, 8'h03, 1'b0, 1'b1);
    chk("R6", "loss wins over clear", int'(ovf), 1);
    pop(); pop();
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk("R6", "cleared later", int'(ovf), 0);
  endtask

  task automatic t_same_one();
    push(8'h41);
    cyc(1'b1, 8'h42, 1'b1, 1'b0);
    chk("R7", "valid kept", int'(out_valid), 1);
    chk("R7", "new byte shown", int'(out_data), 'h42);
    pop();
    chk("R7", "empty after", int'(out_valid), 0);
  endtask

  task automatic t_same_two();
    push(8'h51); push(8'h52);
    cyc(1'b1, 8'h53, 1'b1, 1'b0);
    chk("R8", "no overflow", int'(ovf), 0);
    chk("R8", "second byte", int'(out_data), 'h52);
    pop();
    chk("R8", "third byte", int'(out_data), 'h53);
    pop();
    chk("R8", "empty", int'(out_valid), 0);
  endtask

  task automatic t_empty_read();
    pop();
    chk("R10", "still empty", int'(out_valid), 0);
    push(8'h61);
    chk("R10", "byte lands in front", int'(out_data), 'h61);
    pop();
    chk("R10", "one byte only", int'(out_valid), 0);
  endtask

  task automatic t_disable();
    push(8'h71); push(8'h72); push(8'h73);
    enable = 1'b0;
    cyc(1'b1, 8'h74, 1'b0, 1'b0);
    chk("R9", "valid cleared", int'(out_valid), 0);
    chk("R9", "ovf cleared", int'(ovf), 0);
    enable = 1'b1;
    cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R9", "ignored input", int'(out_valid), 0);
    push(8'h75);
    chk("R9", "front after re-enable", int'(out_data), 'h75);
    pop();
    chk("R9", "single byte", int'(out_valid), 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_overrun();
    t_clr_collision();
    t_same_one();
    t_same_two();
    t_empty_read();
    t_disable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule